// File: doc/BRIEF.md
# Open-Row DRAM Bank Command Sequencer

This block turns single memory requests into the timed command stream for one DRAM bank. It accepts a request carrying bank, row, column and a read/write flag, then emits activate, column (read or write), precharge and no-operation commands on a registered command port. A data-valid strobe marks the cycles in which the burst would be on the data bus. The block keeps the last activated row open after an access. A later request to that same bank and row goes straight to the column command. A request to any other row first waits until the open row has been active long enough, then closes it, waits for the precharge to settle, reopens the new row and waits for the row-to-column delay.

All timing gaps are held in half-clock ticks, so a CAS latency of two and a half cycles is exact. The data strobe then rises on the next whole cycle and is flagged as starting half a cycle early. The four timing settings are small codes, and software keeps them stable while requests are in flight. The request port takes one request at a time and only while the sequencer is idle.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset no row is open, `req_ready_o` is 1, `cmd_o` is NOP and `data_vld_o` is 0.
- R2: Command codes on `cmd_o` are {ras_n, cas_n, we_n}: activate 3'b011, read 3'b101, write 3'b100, precharge 3'b010, NOP 3'b111.
- R3: A request accepted at an edge while no row is open drives activate, with `cmd_bank_o` and the row on `cmd_addr_o`, in the cycle right after that edge. The column command, carrying the column, follows exactly tRCD cycles later.
- R4: Code mapping. Precharge-to-activate is 2, 3, 4, 4 cycles for `cfg_trp_i` 0..3. Activate-to-column is 2, 3, 4, 4 cycles for `cfg_trcd_i` 0..3. Activate-to-precharge minimum is 5 + `cfg_tras_i` cycles.
- R5: CAS latency is 2, 2.5, 3 and 3 cycles for `cfg_cl_i` 0..3. `data_vld_o` first rises ceil(CL) cycles after the column command. `data_half_o` is 1 exactly while `data_vld_o` is 1 and CL is 2.5.
- R6: `data_vld_o` stays high for BURST_LEN consecutive cycles, and `req_ready_o` returns in the cycle after the last one.
- R7: A request to the open bank and row drives its column command in the cycle after acceptance, with no activate or precharge.
- R8: A request to another bank or row drives precharge at the later of (cycle after acceptance) and (activate cycle + tRAS). Activate of the new row follows tRP cycles after the precharge, and the R3 column timing then applies.
- R9: `req_ready_o` is 0 from acceptance until the sequence ends. A request presented while not ready is ignored and changes no later command.
- R10: `cmd_o` is NOP in every cycle in which no other command is due.
- R11: A write request drives the write code in place of the read code, with the same timing and data strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_trp_i | input | 2 | Precharge period code |
| cfg_trcd_i | input | 2 | Row-to-column delay code |
| cfg_cl_i | input | 2 | CAS latency code |
| cfg_tras_i | input | 2 | Minimum row-active time code |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken at this edge if valid |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cmd_o | output | 3 | Command code {ras_n, cas_n, we_n} |
| cmd_bank_o | output | BANK_W | Bank for the current command |
| cmd_addr_o | output | ADDR_W | Row (activate) or column (read/write) |
| data_vld_o | output | 1 | Burst data on the bus this cycle |
| data_half_o | output | 1 | Burst began half a cycle before this strobe |

## Verification
The hardest case to reach is a row miss that must stall on tRAS. The miss has to arrive before the previous activate has aged long enough, which happens only when a closed-row access with short tRCD and CAS latency is followed at once by a miss under a long tRAS. The bench sweeps every code of all four timing fields. Under each setting it issues a closed-row access, then a back-to-back miss to a different bank, then a hit with junk requests held during the busy window, and after an idle gap a miss that is already past tRAS. Command times are derived arithmetically from the codes and compared at every cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   localparam int TICKS_PER_CLK = 2;
   localparam int CFG_W         = 2;

   typedef enum logic [2:0] {
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_NOP = 3'b111
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TRAS,
      ST_TRP,
      ST_TRCD,
      ST_CAS,
      ST_BURST
   } state_e;
endpackage

// File: rtl/dbs_cfg_decode.sv
module dbs_cfg_decode
   import dbs_pkg::*;
#(
   parameter int TW         = 5,
   parameter int TRP_MIN    = 2,
   parameter int TRP_SPAN   = 2,
   parameter int TRCD_MIN   = 2,
   parameter int TRCD_SPAN  = 2,
   parameter int TRAS_MIN   = 5,
   parameter int TRAS_SPAN  = 3,
   parameter int CL_MIN     = 2,
   parameter bit CL_HALF_EN = 1'b1
) (
   input  logic [CFG_W-1:0] cfg_trp_i,
   input  logic [CFG_W-1:0] cfg_trcd_i,
   input  logic [CFG_W-1:0] cfg_cl_i,
   input  logic [CFG_W-1:0] cfg_tras_i,
   output logic [TW-1:0]    trp_h_o,
   output logic [TW-1:0]    trcd_h_o,
   output logic [TW-1:0]    tras_h_o,
   output logic [TW-1:0]    cl_h_o,
   output logic             cl_frac_o
);
   localparam int MAX_H = (TRAS_MIN + TRAS_SPAN) * TICKS_PER_CLK;

   initial begin
      assert (MAX_H < (1 << TW)) else $error("TW too narrow for tRAS");
      assert (TRP_MIN >= 1 && TRCD_MIN >= 1 && CL_MIN >= 1) else $error("timing minimum below one cycle");
   end

   function automatic int clip(input int code, input int span);
      return (code > span) ? span : code;
   endfunction

   always_comb begin
      trp_h_o  = TW'((TRP_MIN  + clip(int'(cfg_trp_i),  TRP_SPAN))  * TICKS_PER_CLK);
      trcd_h_o = TW'((TRCD_MIN + clip(int'(cfg_trcd_i), TRCD_SPAN)) * TICKS_PER_CLK);
      tras_h_o = TW'((TRAS_MIN + clip(int'(cfg_tras_i), TRAS_SPAN)) * TICKS_PER_CLK);
   end

   generate
      if (CL_HALF_EN) begin : g_cl_half
         // half-cycle steps: code 0 -> CL_MIN, 1 -> CL_MIN+0.5, 2/3 -> CL_MIN+1
         always_comb begin
            cl_h_o    = TW'(CL_MIN * TICKS_PER_CLK + clip(int'(cfg_cl_i), 2));
            cl_frac_o = (cfg_cl_i == 2'd1);
         end
      end else begin : g_cl_whole
         always_comb begin
            cl_h_o    = TW'((CL_MIN + clip(int'(cfg_cl_i), 1)) * TICKS_PER_CLK);
            cl_frac_o = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/dbs_half_timer.sv
module dbs_half_timer
   import dbs_pkg::*;
#(
   parameter int TW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          expired_o
);
   localparam logic [TW-1:0] STEP = TW'(TICKS_PER_CLK);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (load_i)       cnt_q <= val_i;
      else if (cnt_q > STEP) cnt_q <= cnt_q - STEP;
      else                   cnt_q <= '0;
   end

   // expired when at most one clock of ticks remain: the next edge may fire
   assign expired_o = (cnt_q <= STEP);

   p_armed_after_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && val_i > STEP) |=> !expired_o);
endmodule

// File: rtl/dbs_burst_gen.sv
module dbs_burst_gen #(
   parameter int BURST_LEN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic frac_i,
   output logic vld_o,
   output logic half_o,
   output logic last_o
);
   initial assert (BURST_LEN >= 1) else $error("BURST_LEN must be at least 1");

   generate
      if (BURST_LEN == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               vld_o  <= 1'b0;
               half_o <= 1'b0;
            end else begin
               vld_o  <= start_i;
               half_o <= start_i & frac_i;
            end
         end
         assign last_o = vld_o;
      end else begin : g_multi
         localparam int CW = $clog2(BURST_LEN);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               vld_o  <= 1'b0;
               half_o <= 1'b0;
               left_q <= '0;
            end else if (start_i) begin
               vld_o  <= 1'b1;
               half_o <= frac_i;
               left_q <= CW'(BURST_LEN - 1);
            end else if (vld_o) begin
               if (left_q == '0) begin
                  vld_o  <= 1'b0;
                  half_o <= 1'b0;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
         end
         assign last_o = vld_o && (left_q == '0);
      end
   endgenerate

   p_start_when_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !vld_o);
   p_half_inside_burst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      half_o |-> vld_o);
endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              act_i,
   input  logic              pre_i,
   input  logic [BANK_W-1:0] act_bank_i,
   input  logic [ROW_W-1:0]  act_row_i,
   input  logic [BANK_W-1:0] q_bank_i,
   input  logic [ROW_W-1:0]  q_row_i,
   output logic              open_o,
   output logic              hit_o
);
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         open_o <= 1'b0;
         bank_q <= '0;
         row_q  <= '0;
      end else if (act_i) begin
         open_o <= 1'b1;
         bank_q <= act_bank_i;
         row_q  <= act_row_i;
      end else if (pre_i) begin
         open_o <= 1'b0;
      end
   end

   assign hit_o = open_o && (bank_q == q_bank_i) && (row_q == q_row_i);

   p_close_only_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_i |-> open_o);
   p_open_only_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |-> !open_o);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
   import dbs_pkg::*;
#(
   parameter int BANK_W     = 2,
   parameter int ROW_W      = 13,
   parameter int COL_W      = 10,
   parameter int BURST_LEN  = 4,
   parameter bit CL_HALF_EN = 1'b1,
   parameter int TW         = 5,
   localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        cfg_trp_i,
   input  logic [1:0]        cfg_trcd_i,
   input  logic [1:0]        cfg_cl_i,
   input  logic [1:0]        cfg_tras_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [BANK_W-1:0] req_bank_i,
   input  logic [ROW_W-1:0]  req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   input  logic              req_write_i,
   output logic [2:0]        cmd_o,
   output logic [BANK_W-1:0] cmd_bank_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic              data_vld_o,
   output logic              data_half_o
);
   initial begin
      assert (BANK_W >= 1 && ROW_W >= 1 && COL_W >= 1) else $error("address widths must be positive");
      assert (CFG_W == 2) else $error("config code width mismatch");
   end

   logic [TW-1:0] trp_h, trcd_h, tras_h, cl_h;
   logic          cl_frac;

   dbs_cfg_decode #(.TW(TW), .CL_HALF_EN(CL_HALF_EN)) u_dec (
      .cfg_trp_i (cfg_trp_i),  .cfg_trcd_i(cfg_trcd_i),
      .cfg_cl_i  (cfg_cl_i),   .cfg_tras_i(cfg_tras_i),
      .trp_h_o   (trp_h),      .trcd_h_o  (trcd_h),
      .tras_h_o  (tras_h),     .cl_h_o    (cl_h),
      .cl_frac_o (cl_frac)
   );

   state_e            state_q, state_d;
   logic              accept;
   logic              do_pre, do_act, do_col, do_data;
   logic              dly_ok, tras_ok, row_open, row_hit, burst_last;
   logic [BANK_W-1:0] lat_bank, cur_bank;
   logic [ROW_W-1:0]  lat_row, cur_row;
   logic [COL_W-1:0]  lat_col, cur_col;
   logic              lat_wr, cur_wr;
   logic [TW-1:0]     dly_val;

   assign req_ready_o = (state_q == ST_IDLE);
   assign accept      = req_valid_i && req_ready_o;

   // in idle the request itself is used so the first command leaves at once
   always_comb begin
      if (state_q == ST_IDLE) begin
         cur_bank = req_bank_i;
         cur_row  = req_row_i;
         cur_col  = req_col_i;
         cur_wr   = req_write_i;
      end else begin
         cur_bank = lat_bank;
         cur_row  = lat_row;
         cur_col  = lat_col;
         cur_wr   = lat_wr;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lat_bank <= '0;
         lat_row  <= '0;
         lat_col  <= '0;
         lat_wr   <= 1'b0;
      end else if (accept) begin
         lat_bank <= req_bank_i;
         lat_row  <= req_row_i;
         lat_col  <= req_col_i;
         lat_wr   <= req_write_i;
      end
   end

   dbs_row_track #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_row (
      .clk_i      (clk_i),    .rst_ni   (rst_ni),
      .act_i      (do_act),   .pre_i    (do_pre),
      .act_bank_i (cur_bank), .act_row_i(cur_row),
      .q_bank_i   (req_bank_i), .q_row_i(req_row_i),
      .open_o     (row_open), .hit_o    (row_hit)
   );

   always_comb begin
      state_d = state_q;
      do_pre  = 1'b0;
      do_act  = 1'b0;
      do_col  = 1'b0;
      do_data = 1'b0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            if (row_hit)       do_col  = 1'b1;
            else if (!row_open) do_act = 1'b1;
            else if (tras_ok)  do_pre  = 1'b1;
            else               state_d = ST_TRAS;
         end
         ST_TRAS:  if (tras_ok) do_pre = 1'b1;
         ST_TRP:   if (dly_ok)  do_act = 1'b1;
         ST_TRCD:  if (dly_ok)  do_col = 1'b1;
         ST_CAS:   if (dly_ok) begin
            do_data = 1'b1;
            state_d = ST_BURST;
         end
         ST_BURST: if (burst_last) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
      if (do_pre) state_d = ST_TRP;
      if (do_act) state_d = ST_TRCD;
      if (do_col) state_d = ST_CAS;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   always_comb begin
      if (do_pre)      dly_val = trp_h;
      else if (do_act) dly_val = trcd_h;
      else             dly_val = cl_h;
   end

   dbs_half_timer #(.TW(TW)) u_gap (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(do_pre | do_act | do_col), .val_i(dly_val), .expired_o(dly_ok)
   );

   dbs_half_timer #(.TW(TW)) u_tras (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(do_act), .val_i(tras_h), .expired_o(tras_ok)
   );

   dbs_burst_gen #(.BURST_LEN(BURST_LEN)) u_burst (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .start_i(do_data), .frac_i(cl_frac),
      .vld_o(data_vld_o), .half_o(data_half_o), .last_o(burst_last)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmd_o      <= CMD_NOP;
         cmd_bank_o <= '0;
         cmd_addr_o <= '0;
      end else begin
         cmd_bank_o <= cur_bank;
         if (do_pre) begin
            cmd_o      <= CMD_PRE;
            cmd_addr_o <= '0;
         end else if (do_act) begin
            cmd_o      <= CMD_ACT;
            cmd_addr_o <= ADDR_W'(cur_row);
         end else if (do_col) begin
            cmd_o      <= cur_wr ? CMD_WR : CMD_RD;
            cmd_addr_o <= ADDR_W'(cur_col);
         end else begin
            cmd_o      <= CMD_NOP;
            cmd_addr_o <= '0;
         end
      end
   end

   // ---- timing guards: cycle distances measured on the command port ----
   logic [3:0] since_act, since_pre, since_col;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         since_act <= 4'hF;
         since_pre <= 4'hF;
         since_col <= 4'hF;
      end else begin
         since_act <= (cmd_o == CMD_ACT) ? 4'd1 : ((since_act == 4'hF) ? since_act : since_act + 4'd1);
         since_pre <= (cmd_o == CMD_PRE) ? 4'd1 : ((since_pre == 4'hF) ? since_pre : since_pre + 4'd1);
         since_col <= (cmd_o == CMD_RD || cmd_o == CMD_WR) ? 4'd1
                      : ((since_col == 4'hF) ? since_col : since_col + 4'd1);
      end
   end

   p_tras_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_PRE) |-> (int'(since_act) * 2 >= int'(tras_h)));
   p_trp_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_ACT) |-> (int'(since_pre) * 2 >= int'(trp_h)));
   p_trcd_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> (int'(since_act) * 2 >= int'(trcd_h)));
   p_cas_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(data_vld_o) |-> (int'(since_col) == (int'(cl_h) + 1) / 2));
   p_idle_is_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |-> (cmd_o == CMD_NOP && !data_vld_o));
   p_busy_after_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> !req_ready_o);
endmodule

// File: tb/dram_bank_seq_tb_top.sv
`timescale 1ns/1ps
module dram_bank_seq_tb_top;
   localparam int BANK_W = 2;
   localparam int ROW_W  = 4;
   localparam int COL_W  = 3;
   localparam int BL     = 2;
   localparam int ADDR_W = 4;

   localparam logic [2:0] C_PRE = 3'b010, C_ACT = 3'b011, C_WR = 3'b100,
                          C_RD  = 3'b101, C_NOP = 3'b111;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        trp_c = '0, trcd_c = '0, cl_c = '0, tras_c = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic              req_wr = 1'b0;
   logic [2:0]        cmd;
   logic [BANK_W-1:0] cmd_bank;
   logic [ADDR_W-1:0] cmd_addr;
   logic              dvld, dhalf;

   always #2.5 clk = ~clk;

   dram_bank_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BL)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_trp_i(trp_c), .cfg_trcd_i(trcd_c), .cfg_cl_i(cl_c), .cfg_tras_i(tras_c),
      .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_write_i(req_wr),
      .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
      .data_vld_o(dvld), .data_half_o(dhalf)
   );

   int cyc = 0;
   int n_tests = 0, n_fail = 0;
   bit m_open;
   int m_bank, m_row, m_act;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: got %0d expected %0d", rq, what, cyc, act, exp);
      end
   endtask

   function automatic int trp_cyc();  return (trp_c  == 2'd3) ? 4 : int'(trp_c)  + 2; endfunction
   function automatic int trcd_cyc(); return (trcd_c == 2'd3) ? 4 : int'(trcd_c) + 2; endfunction
   function automatic int tras_cyc(); return int'(tras_c) + 5; endfunction
   function automatic int cl_ceil();  return (cl_c == 2'd0) ? 2 : 3; endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      chk(cmd == C_NOP, "R1", "cmd after reset", int'(cmd), int'(C_NOP));
      chk(dvld == 1'b0, "R1", "data_vld after reset", int'(dvld), 0);
      m_open = 1'b0;
   endtask

   task automatic idle_gap(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(cmd == C_NOP, "R10", "idle cmd", int'(cmd), int'(C_NOP));
         chk(req_ready == 1'b1, "R9", "idle ready", int'(req_ready), 1);
      end
   endtask

   // called at a negedge with ready high; returns at the negedge where ready is back
   task automatic access(input int bank, input int row, input int col, input bit wr, input bit junk);
      int e, p, a, c, d, fin;
      bit hit;
      req_bank  = BANK_W'(bank);
      req_row   = ROW_W'(row);
      req_col   = COL_W'(col);
      req_wr    = wr;
      req_valid = 1'b1;
      @(negedge clk);
      e = cyc;
      if (junk) begin
         // held during the busy window; must be ignored (R9)
         req_bank = BANK_W'(bank ^ 1);
         req_row  = ROW_W'(~row);
         req_wr   = ~wr;
      end else begin
         req_valid = 1'b0;
      end
      hit = m_open && (m_bank == bank) && (m_row == row);
      p = -1;
      a = -1;
      if (hit) c = e;
      else if (!m_open) begin
         a = e;
         c = a + trcd_cyc();
      end else begin
         p = (e > m_act + tras_cyc()) ? e : m_act + tras_cyc();
         a = p + trp_cyc();
         c = a + trcd_cyc();
      end
      d   = c + cl_ceil();
      fin = d + BL;
      for (int t = e; t <= fin; t++) begin
         if (t > e) @(negedge clk);
         if (t == p) begin
            chk(cmd == C_PRE, "R8", "precharge cmd", int'(cmd), int'(C_PRE));
         end else if (t == a) begin
            chk(cmd == C_ACT, (p >= 0) ? "R4" : "R3", "activate cmd", int'(cmd), int'(C_ACT));
            chk(int'(cmd_addr) == row, "R3", "activate row", int'(cmd_addr), row);
            chk(int'(cmd_bank) == bank, "R3", "activate bank", int'(cmd_bank), bank);
         end else if (t == c) begin
            // R2 codes: read 101, write 100
            chk(cmd == (wr ? C_WR : C_RD), wr ? "R11" : (hit ? "R7" : "R3"), "column cmd",
                int'(cmd), int'(wr ? C_WR : C_RD));
            chk(int'(cmd_addr) == col, hit ? "R7" : "R4", "column addr", int'(cmd_addr), col);
            chk(int'(cmd_bank) == bank, "R2", "column bank", int'(cmd_bank), bank);
         end else begin
            chk(cmd == C_NOP, "R10", "nop cmd", int'(cmd), int'(C_NOP));
         end
         chk(dvld == (t >= d && t < fin), "R6", "data_vld", int'(dvld), int'(t >= d && t < fin));
         chk(dhalf == ((t >= d && t < fin) && cl_c == 2'd1), "R5", "data_half", int'(dhalf),
             int'((t >= d && t < fin) && cl_c == 2'd1));
         chk(req_ready == (t == fin), "R9", "ready", int'(req_ready), int'(t == fin));
      end
      req_valid = 1'b0;
      if (a >= 0) m_act = a;
      m_open = 1'b1;
      m_bank = bank;
      m_row  = row;
   endtask

   initial begin
      for (int ip = 0; ip < 4; ip++)
         for (int ic = 0; ic < 4; ic++)
            for (int il = 0; il < 4; il++)
               for (int is = 0; is < 4; is++) begin
                  trp_c  = 2'(ip);
                  trcd_c = 2'(ic);
                  cl_c   = 2'(il);
                  tras_c = 2'(is);
                  do_reset();
                  access(1, 5, 2, 1'b0, 1'b0);  // closed row (R3), same row as last hit before reset
                  access(3, 9, 6, 1'b0, 1'b0);  // bank miss at once: tRAS may bind (R8)
                  access(3, 9, 1, 1'b1, 1'b1);  // hit, write, junk held while busy (R7 R11 R9)
                  idle_gap(9);
                  access(1, 5, 7, 1'b0, 1'b0);  // row miss past tRAS (R8 R4)
                  access(1, 5, 3, 1'b1, 1'b0);  // hit write (R7 R11)
               end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #950000;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule